// File: doc/BRIEF.md
# Conditional relative branch unit

This block resolves one conditional branch per accepted instruction word for a 16-bit core that addresses a 20-bit space. It recognises the branch opcode, compares one of eight fixed conditions with the negative (N), zero (Z), carry (C) and overflow (V) flags, and works out the address the core fetches from next. The program counter given to the block already points at the word that follows the branch.

When `valid_i` is high on a rising clock edge, the block captures three results: whether the word is a branch, whether the branch is taken, and the next program counter. A taken branch gives the PC plus twice the sign-extended 10-bit word offset, wrapped to 20 bits. In every other case the next PC is the input PC. When `valid_i` is low the results keep their values.

The block has one result register and no sequencing. Its only named behaviour is the load/hold choice: on a valid edge it loads (LOAD), and otherwise it keeps its value (HOLD). The block has no flag output, so it cannot write the N, Z, C or V flags.

Top module: `crb_unit`

## Requirements
- R1: A high `rst` on a rising edge clears `taken_o` and `is_jump_o` to 0 and sets `next_pc_o` to 0 on that edge. Reset takes priority over `valid_i`.
- R2: The word is a branch only when bits 15..13 are 001. For any other value, a valid edge gives `is_jump_o`=0, `taken_o`=0 and `next_pc_o` equal to the PC sampled on that edge.
- R3: Bits 12..10 select the condition: 000 Z clear, 001 Z set, 010 C clear, 011 C set, 100 N set, 101 N XOR V = 0, 110 N XOR V = 1, 111 always. The flag inputs are one bit each. For a branch word, a valid edge sets `taken_o` to the selected condition and `is_jump_o` to 1.
- R4: For a taken branch, `next_pc_o` equals the PC plus 2 × offset. The offset is bits 9..0 read as a two's-complement number, with bit 9 as the sign.
- R5: For a branch whose condition is false, a valid edge gives `taken_o`=0 and `next_pc_o` equal to the sampled PC.
- R6: The extreme offsets reach exactly PC+1022 (field 0x1FF) and PC−1024 (field 0x200).
- R7: The target addition wraps modulo 2^20 past both the top and the bottom of the address space.
- R8: A clock edge with `valid_i` low and `rst` low leaves all three outputs unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Accept the inputs on this edge |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 20 | PC of the word after the branch |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| taken_o | output | 1 | Registered branch-taken result |
| next_pc_o | output | 20 | Registered next program counter |
| is_jump_o | output | 1 | Registered branch-recognised result |

## Verification
The properties assume that `valid_i`, the instruction word, the PC and the flags are settled, with no unknown bits, at every rising edge. They also assume that the sampled PC is the value that should be relayed whenever no branch is taken. Every input may change freely between edges. To stay within these assumptions, the stimulus changes all inputs only on falling edges and drives only defined values. It also varies the instruction word and the PC during edges where `valid_i` is low, so that the hold property sees changing inputs.

// File: rtl/crb_pkg.sv
package crb_pkg;
    localparam int INSTR_W = 16;
    localparam int ADDR_W  = 20;
    localparam int OFS_W   = 10;
    localparam int OP_W    = 3;
    localparam int CND_W   = 3;
    localparam logic [OP_W-1:0] JUMP_OPCODE = 3'b001;

    typedef enum logic [CND_W-1:0] {
        COND_ZC = 3'd0,
        COND_ZS = 3'd1,
        COND_CC = 3'd2,
        COND_CS = 3'd3,
        COND_NS = 3'd4,
        COND_GE = 3'd5,
        COND_LT = 3'd6,
        COND_AL = 3'd7
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_LOAD = 1'b1
    } upd_e;
endpackage

// File: rtl/crb_decode.sv
module crb_decode
    import crb_pkg::*;
#(
    parameter int IW = INSTR_W,
    parameter int OW = OFS_W
) (
    input  logic [IW-1:0] word_i,
    output logic          is_jump_o,
    output cond_e         cond_o,
    output logic [OW-1:0] offset_o
);
    localparam int OP_LSB  = IW - OP_W;
    localparam int CND_LSB = OP_LSB - CND_W;

    always_comb begin
        is_jump_o = (word_i[IW-1:OP_LSB] == JUMP_OPCODE);
        cond_o    = cond_e'(word_i[OP_LSB-1:CND_LSB]);
        offset_o  = word_i[OW-1:0];
    end
endmodule

// File: rtl/crb_cond_eval.sv
module crb_cond_eval
    import crb_pkg::*;
(
    input  cond_e  cond_i,
    input  flags_t flags_i,
    output logic   pass_o
);
    logic lt;

    always_comb begin
        lt = flags_i.n ^ flags_i.v;
        unique case (cond_i)
            COND_ZC: pass_o = ~flags_i.z;
            COND_ZS: pass_o =  flags_i.z;
            COND_CC: pass_o = ~flags_i.c;
            COND_CS: pass_o =  flags_i.c;
            COND_NS: pass_o =  flags_i.n;
            COND_GE: pass_o = ~lt;
            COND_LT: pass_o =  lt;
            COND_AL: pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/crb_target_add.sv
module crb_target_add
    import crb_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OFS_W
) (
    input  logic [AW-1:0] pc_i,
    input  logic [OW-1:0] offset_i,
    output logic [AW-1:0] target_o
);
    localparam int EXT_W = AW - OW - 1;

    logic [AW-1:0] byte_ofs;

    generate
        if (EXT_W > 0) begin : g_ext
            assign byte_ofs = {{EXT_W{offset_i[OW-1]}}, offset_i, 1'b0};
        end else begin : g_trim
            assign byte_ofs = {offset_i[AW-2:0], 1'b0};
        end
    endgenerate

    assign target_o = pc_i + byte_ofs;
endmodule

// File: rtl/crb_unit.sv
module crb_unit
    import crb_pkg::*;
#(
    parameter int IW = INSTR_W,
    parameter int AW = ADDR_W,
    parameter int OW = OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [IW-1:0] instr_i,
    input  logic [AW-1:0] pc_i,
    input  logic          flag_n_i,
    input  logic          flag_z_i,
    input  logic          flag_c_i,
    input  logic          flag_v_i,
    output logic          taken_o,
    output logic [AW-1:0] next_pc_o,
    output logic          is_jump_o
);
    logic          dec_jump;
    cond_e         dec_cond;
    logic [OW-1:0] dec_ofs;
    logic          cond_pass;
    logic [AW-1:0] tgt;
    flags_t        flags;
    upd_e          upd;

    logic          taken_d, jump_d;
    logic [AW-1:0] pc_d;
    logic          taken_q, jump_q;
    logic [AW-1:0] pc_q;

    assign flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

    crb_decode #(.IW(IW), .OW(OW)) u_dec (
        .word_i    (instr_i),
        .is_jump_o (dec_jump),
        .cond_o    (dec_cond),
        .offset_o  (dec_ofs)
    );

    crb_cond_eval u_cond (
        .cond_i  (dec_cond),
        .flags_i (flags),
        .pass_o  (cond_pass)
    );

    crb_target_add #(.AW(AW), .OW(OW)) u_add (
        .pc_i     (pc_i),
        .offset_i (dec_ofs),
        .target_o (tgt)
    );

    always_comb begin
        upd     = valid_i ? ST_LOAD : ST_HOLD;
        taken_d = taken_q;
        jump_d  = jump_q;
        pc_d    = pc_q;
        unique case (upd)
            ST_LOAD: begin
                jump_d  = dec_jump;
                taken_d = dec_jump & cond_pass;
                pc_d    = (dec_jump & cond_pass) ? tgt : pc_i;
            end
            ST_HOLD: begin
                taken_d = taken_q;
            end
            default: begin
                taken_d = taken_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= 1'b0;
            jump_q  <= 1'b0;
            pc_q    <= '0;
        end else begin
            taken_q <= taken_d;
            jump_q  <= jump_d;
            pc_q    <= pc_d;
        end
    end

    assign taken_o   = taken_q;
    assign is_jump_o = jump_q;
    assign next_pc_o = pc_q;
endmodule

// File: rtl/crb_unit_chk.sv
module crb_unit_chk #(
    parameter int IW = 16,
    parameter int AW = 20,
    parameter int OW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          valid_i,
    input logic [IW-1:0] instr_i,
    input logic [AW-1:0] pc_i,
    input logic          taken_o,
    input logic [AW-1:0] next_pc_o,
    input logic          is_jump_o
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!taken_o && !is_jump_o && next_pc_o == '0));

    p_nonjump_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i[IW-1:IW-3] != 3'b001)
        |=> (!is_jump_o && !taken_o && next_pc_o == $past(pc_i)));

    p_always_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i[IW-1:IW-6] == 6'b001111) |=> (taken_o && is_jump_o));

    p_taken_is_jump_r3: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> is_jump_o);

    p_target_r4: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (!taken_o || next_pc_o == AW'($past(pc_i)
            + AW'({{(AW-OW){$past(instr_i[OW-1])}}, $past(instr_i[OW-1:0])} << 1))));

    p_fallthrough_r5: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (taken_o || next_pc_o == $past(pc_i)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(taken_o) && $stable(is_jump_o) && $stable(next_pc_o)));
endmodule

bind crb_unit crb_unit_chk #(.IW(IW), .AW(AW), .OW(OW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .pc_i      (pc_i),
    .taken_o   (taken_o),
    .next_pc_o (next_pc_o),
    .is_jump_o (is_jump_o)
);

// File: tb/sim_crb_unit.sv
`timescale 1ns/1ps
module sim_crb_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [19:0] pc_i = '0;
    logic        fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;
    logic        taken_o, is_jump_o;
    logic [19:0] next_pc_o;

    typedef struct {
        logic        tk;
        logic        jp;
        logic [19:0] pc;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    exp_t last;

    always #2.5 clk = ~clk;

    crb_unit u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
        .flag_n_i(fn), .flag_z_i(fz), .flag_c_i(fc), .flag_v_i(fv),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .is_jump_o(is_jump_o)
    );

    function automatic exp_t model(input logic [15:0] w, input logic [19:0] pc,
                                   input logic n, z, c, v, input string req);
        exp_t e;
        int   so;
        logic ok;
        e.req = req;
        e.jp  = (w[15:13] == 3'b001);
        case (w[12:10])
            3'd0: ok = !z;
            3'd1: ok = z;
            3'd2: ok = !c;
            3'd3: ok = c;
            3'd4: ok = n;
            3'd5: ok = (n == v);
            3'd6: ok = (n != v);
            default: ok = 1'b1;
        endcase
        e.tk = e.jp && ok;
        so = (w[9:0] >= 10'd512) ? int'(w[9:0]) - 1024 : int'(w[9:0]);
        e.pc = e.tk ? 20'((int'(pc) + 2 * so + 32'h0010_0000) & 32'h000F_FFFF) : pc;
        return e;
    endfunction

    task automatic check(input string req, input logic tk, jp, input logic [19:0] pc,
                         input exp_t e);
        n_chk++;
        if (tk !== e.tk || jp !== e.jp || pc !== e.pc) begin
            n_bad++;
            $display("FAIL %s: got taken=%b jump=%b pc=%05h, want taken=%b jump=%b pc=%05h",
                     req, tk, jp, pc, e.tk, e.jp, e.pc);
        end
    endtask

    task automatic drive(input logic [15:0] w, input logic [19:0] pc,
                         input logic [3:0] f, input string req);
        @(negedge clk);
        valid_i = 1'b1; instr_i = w; pc_i = pc;
        {fn, fz, fc, fv} = f;
        last = model(w, pc, f[3], f[2], f[1], f[0], req);
        q.push_back(last);
    endtask

    task automatic idle_hold();
        @(negedge clk);
        valid_i = 1'b0;
        while (q.size() != 0) @(negedge clk);
        instr_i = 16'h3C05; pc_i = 20'h5A5A5; {fn, fz, fc, fv} = 4'hF;
        repeat (3) @(negedge clk);
        check("R8", taken_o, is_jump_o, next_pc_o, last);
    endtask

    always begin
        @(posedge clk);
        if (valid_i && !rst) begin
            exp_t e;
            @(negedge clk);
            e = q.pop_front();
            check(e.req, taken_o, is_jump_o, next_pc_o, e);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed = 32'h1234_5678;
        exp_t zero;
        zero.tk = 0; zero.jp = 0; zero.pc = '0; zero.req = "R1";
        repeat (3) @(negedge clk);
        valid_i = 1'b1; instr_i = 16'h3C10; pc_i = 20'h12345;
        @(negedge clk);
        check("R1", taken_o, is_jump_o, next_pc_o, zero);
        valid_i = 1'b0; rst = 1'b0;

        // R3 R4 R5: every condition against every flag combination
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                drive({3'b001, 3'(c), seed[9:0]}, seed[31:12], 4'(f),
                      (c == 7) ? "R3" : (((c + f) % 2) == 0 ? "R4" : "R5"));
            end
        end

        // R2: every non-branch opcode
        for (int op = 0; op < 8; op++) begin
            if (op != 1) drive({3'(op), 3'd7, 10'h155}, 20'h0ABCD, 4'hF, "R2");
        end

        // R6: extreme offsets
        drive({3'b001, 3'd7, 10'h1FF}, 20'h40000, 4'h0, "R6");
        drive({3'b001, 3'd7, 10'h200}, 20'h40000, 4'h0, "R6");

        // R7: wrap at top and bottom
        drive({3'b001, 3'd7, 10'h001}, 20'hFFFFE, 4'h0, "R7");
        drive({3'b001, 3'd7, 10'h3FC}, 20'h00002, 4'h0, "R7");
        drive({3'b001, 3'd7, 10'h200}, 20'h00000, 4'h0, "R7");

        // R8: hold while idle
        idle_hold();
        drive({3'b001, 3'd1, 10'h010}, 20'h00100, 4'h0, "R5");
        idle_hold();

        // R1: reset in mid-run beats valid
        @(negedge clk);
        rst = 1'b1; valid_i = 1'b1; instr_i = 16'h3C10;
        @(negedge clk);
        check("R1", taken_o, is_jump_o, next_pc_o, zero);
        rst = 1'b0; valid_i = 1'b0;
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule